// File: doc/BRIEF.md
# Lane-Replicating Narrow-Write Register Bus

This block joins a processor-side access port to a small bank of 32-bit scratch registers over a single 32-bit write bus that carries no byte enables. The master-side adapter takes an access made of an address, a transfer size, write data and write and read enables. For a byte or halfword write, it copies the narrow value into every lane of the write bus. The register bank always stores the complete bus word, whatever the transfer size and whatever the low address bits. A narrow write therefore fills the whole register with copies of the written value.

Reads always fetch the full word from the register that the address selects. The master-side adapter then picks the addressed byte or halfword in little-endian order, zero-extends it, and registers the result one clock after the request. Software that needs to change part of a register must therefore write the whole word, or accept the replicated pattern.

Top module: `nwr_regbus`

## Requirements
- R1: After reset, `rd_data` is zero and each of the four registers reads back as 0x00000000.
- R2: When `acc_size` is 2'b00 (byte), `wbus_data` equals `acc_wdata[7:0]` copied into all four byte lanes. For example, 0xA5 gives 0xA5A5A5A5.
- R3: When `acc_size` is 2'b01 (halfword), `wbus_data` equals `acc_wdata[15:0]` copied into both halves. For example, 0xF00D gives 0xF00DF00D.
- R4: When `acc_size` is 2'b10 (word) or 2'b11 (treated as word), `wbus_data` equals `acc_wdata` unchanged.
- R5: On a rising edge where `acc_we` is high, the register selected by `acc_addr[3:2]` takes all 32 bits of `wbus_data`, whatever `acc_addr[1:0]` and the size are. A byte write of 0x3C at offset 1 therefore leaves 0x3C3C3C3C.
- R6: A write changes only the register selected by `acc_addr[3:2]`. The other three registers keep their values.
- R7: A byte read returns, zero-extended, byte lane `acc_addr[1:0]` of the selected register. Lane 0 is bits [7:0] and lane 3 is bits [31:24], so 0xDEADBEEF gives 0xEF, 0xBE, 0xAD and 0xDE for offsets 0 to 3.
- R8: A halfword read returns, zero-extended, bits [15:0] when `acc_addr[1]` is 0 and bits [31:16] when it is 1. `acc_addr[0]` is ignored.
- R9: A read with size 2'b10 or 2'b11 returns the full 32-bit register.
- R10: `rd_data` is loaded on the rising edge where `acc_re` is high, from the register value present before that edge, so a read in the same cycle as a write returns the old value. `rd_data` holds its value while `acc_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 4 | Byte address: [3:2] selects a register, [1:0] selects a lane |
| acc_size | input | 2 | Transfer size: 00 byte, 01 halfword, 10 or 11 word |
| acc_wdata | input | 32 | Write data, with narrow values in the low bits |
| acc_we | input | 1 | Write enable |
| acc_re | input | 1 | Read request |
| wbus_data | output | 32 | Lane-replicated write bus |
| rd_data | output | 32 | Registered, lane-extracted and zero-extended read result |

## Verification
Directed sequences write a known word and read it back at every byte offset and both halfword offsets. This separates correct little-endian lane order from swapped or shifted lanes, and shows whether the zero extension is present. Narrow writes at nonzero offsets, and halfword reads with address bit 0 set, show whether the low address bits are truly ignored on writes and on halfword reads. A read issued in the same cycle as a write to the same register, followed by idle cycles, separates old-value read timing and the hold behaviour from an output that updates every cycle. Random mixes of sizes, offsets and registers, checked against a bench model, expose any crosstalk between registers and any mishandling of size code 2'b11.

// File: rtl/nwr_pkg.sv
package nwr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } nwr_size_e;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned HALF_BITS = 16;

endpackage

// File: rtl/nwr_lane_replicator.sv
module nwr_lane_replicator
  import nwr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  nwr_size_e         size,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] bus_data
);

  localparam int unsigned LANES  = DATA_W / BYTE_BITS;
  localparam int unsigned HALVES = DATA_W / HALF_BITS;

  logic [DATA_W-1:0] byte_fill;
  logic [DATA_W-1:0] half_fill;

  // Copy the narrow value into every lane of its size.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_byte_fill
    assign byte_fill[ln*BYTE_BITS +: BYTE_BITS] = src_data[BYTE_BITS-1:0];
  end

  for (genvar hf = 0; hf < HALVES; hf++) begin : g_half_fill
    assign half_fill[hf*HALF_BITS +: HALF_BITS] = src_data[HALF_BITS-1:0];
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: bus_data = byte_fill;
      SZ_HALF: bus_data = half_fill;
      default: bus_data = src_data;
    endcase
  end

endmodule

// File: rtl/nwr_scratch_bank.sv
module nwr_scratch_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_bus,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] reg_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] reg_d;

    // Next-state: the whole bus word, with no lane masking.
    always_comb begin
      hit   = wr_en && (wr_idx == IDX_W'(r));
      reg_d = wr_bus;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[r] <= '0;
      end else if (hit) begin
        reg_q[r] <= reg_d;
      end
    end
  end

  always_comb begin
    rd_word = reg_q[rd_idx];
  end

endmodule

// File: rtl/nwr_lane_extract.sv
module nwr_lane_extract
  import nwr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / BYTE_BITS,
  localparam int unsigned HALVES = DATA_W / HALF_BITS,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  nwr_size_e         size,
  input  logic [LANE_W-1:0] lane_sel,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);

  logic [BYTE_BITS-1:0] byte_lane [LANES];
  logic [HALF_BITS-1:0] half_lane [HALVES];
  logic [DATA_W-1:0]    result_d;
  logic [DATA_W-1:0]    result_q;

  // Little-endian lane split: lane 0 holds the least significant bits.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_byte_lane
    assign byte_lane[ln] = word[ln*BYTE_BITS +: BYTE_BITS];
  end

  for (genvar hf = 0; hf < HALVES; hf++) begin : g_half_lane
    assign half_lane[hf] = word[hf*HALF_BITS +: HALF_BITS];
  end

  always_comb begin
    result_d = '0;
    unique case (size)
      SZ_BYTE: result_d[BYTE_BITS-1:0] = byte_lane[lane_sel];
      SZ_HALF: result_d[HALF_BITS-1:0] = half_lane[lane_sel[LANE_W-1:1]];
      default: result_d = word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (cap_en) begin
      result_q <= result_d;
    end
  end

  assign result = result_q;

endmodule

// File: rtl/nwr_regbus.sv
module nwr_regbus
  import nwr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned LANE_W  = $clog2(DATA_W / BYTE_BITS),
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned ADDR_W  = LANE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              acc_we,
  input  logic              acc_re,
  output logic [DATA_W-1:0] wbus_data,
  output logic [DATA_W-1:0] rd_data
);

  nwr_size_e         size_q;
  logic [IDX_W-1:0]  reg_idx;
  logic [LANE_W-1:0] lane_sel;
  logic [DATA_W-1:0] bank_word;

  assign size_q   = nwr_size_e'(acc_size);
  assign reg_idx  = acc_addr[LANE_W +: IDX_W];
  assign lane_sel = acc_addr[LANE_W-1:0];

  nwr_lane_replicator #(
    .DATA_W(DATA_W)
  ) u_repl (
    .size    (size_q),
    .src_data(acc_wdata),
    .bus_data(wbus_data)
  );

  // The bank sees only the register index, never the lane bits.
  nwr_scratch_bank #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (acc_we),
    .wr_idx (reg_idx),
    .wr_bus (wbus_data),
    .rd_idx (reg_idx),
    .rd_word(bank_word)
  );

  nwr_lane_extract #(
    .DATA_W(DATA_W)
  ) u_extract (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (acc_re),
    .size    (size_q),
    .lane_sel(lane_sel),
    .word    (bank_word),
    .result  (rd_data)
  );

endmodule

// File: rtl/nwr_regbus_chk.sv
module nwr_regbus_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              acc_we,
  input logic              acc_re,
  input logic [DATA_W-1:0] wbus_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] bank_word
);

  assert_byte_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'b00) |->
      (wbus_data[7:0] == acc_wdata[7:0]) && (wbus_data[15:8] == wbus_data[7:0]) &&
      (wbus_data[31:16] == wbus_data[15:0]));

  assert_half_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'b01) |->
      (wbus_data[15:0] == acc_wdata[15:0]) && (wbus_data[31:16] == acc_wdata[15:0]));

  assert_word_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_size[1] |-> (wbus_data == acc_wdata));

  assert_full_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && rst_n) |=> ((acc_addr[ADDR_W-1:2] != $past(acc_addr[ADDR_W-1:2])) ||
                 (bank_word == $past(wbus_data))));

  assert_byte_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re && acc_size == 2'b00) |=> (rd_data[31:8] == '0));

  assert_half_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re && acc_size == 2'b01) |=> (rd_data[31:16] == '0));

  assert_word_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re && acc_size[1]) |=> (rd_data == $past(bank_word)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_re && rst_n) |=> $stable(rd_data));

endmodule

bind nwr_regbus nwr_regbus_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_addr (acc_addr),
  .acc_size (acc_size),
  .acc_wdata(acc_wdata),
  .acc_we   (acc_we),
  .acc_re   (acc_re),
  .wbus_data(wbus_data),
  .rd_data  (rd_data),
  .bank_word(bank_word)
);

// File: tb/nwr_regbus_tb.sv
module nwr_regbus_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic [3:0]  acc_addr;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic        acc_we;
  logic        acc_re;
  logic [31:0] wbus_data;
  logic [31:0] rd_data;

  int checks;
  int errors;
  bit done;
  logic [31:0] model [4];
  logic [31:0] last_rd;

  nwr_regbus u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_addr (acc_addr),
    .acc_size (acc_size),
    .acc_wdata(acc_wdata),
    .acc_we   (acc_we),
    .acc_re   (acc_re),
    .wbus_data(wbus_data),
    .rd_data  (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] fill(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'b00) return {4{d[7:0]}};
    if (sz == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] off,
                                       input logic [1:0] sz);
    if (sz == 2'b00) return {24'h0, w[8*off +: 8]};
    if (sz == 2'b01) return off[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // One access: drive at a falling edge, let one rising edge pass, then check.
  task automatic access(input string tag, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input bit we, input bit re);
    logic [31:0] exp_rd;
    @(negedge clk);
    check({tag, " idle hold R10"}, rd_data, last_rd);
    acc_addr = a; acc_size = sz; acc_wdata = d; acc_we = we; acc_re = re;
    #1;
    if (we) check({tag, " bus R2 R3 R4"}, wbus_data, fill(sz, d));
    exp_rd = re ? pick(model[a[3:2]], a[1:0], sz) : last_rd;
    @(negedge clk);
    acc_we = 1'b0; acc_re = 1'b0;
    if (we) model[a[3:2]] = fill(sz, d);
    check({tag, " read R7 R8 R9 R10"}, rd_data, exp_rd);
    last_rd = exp_rd;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; acc_addr = '0; acc_size = '0; acc_wdata = '0;
    acc_we = 1'b0; acc_re = 1'b0; last_rd = '0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("reset rd_data R1", rd_data, 32'h0);
    for (int i = 0; i < 4; i++) access("R1 reset word", 4'(i*4), 2'b10, 32'h0, 0, 1);

    // R5 R7: full word, then byte lanes little-endian
    access("R5 word write", 4'h0, 2'b10, 32'hDEADBEEF, 1, 0);
    for (int o = 0; o < 4; o++) access("R7 byte lane", 4'(o), 2'b00, 32'h0, 0, 1);
    // R8 halfword reads, bit 0 ignored
    access("R8 half lo", 4'h0, 2'b01, 32'h0, 0, 1);
    access("R8 half hi", 4'h2, 2'b01, 32'h0, 0, 1);
    access("R8 half hi odd", 4'h3, 2'b01, 32'h0, 0, 1);
    access("R8 half lo odd", 4'h1, 2'b01, 32'h0, 0, 1);
    // R2 R5 narrow writes replicate, offset ignored
    access("R2 byte A5", 4'h0, 2'b00, 32'h123456A5, 1, 0);
    access("R5 check A5", 4'h0, 2'b10, 32'h0, 0, 1);
    check("R2 R5 A5 value", last_rd, 32'hA5A5A5A5);
    access("R5 byte 3C off1", 4'h1, 2'b00, 32'h0000003C, 1, 0);
    access("R5 check 3C", 4'h0, 2'b10, 32'h0, 0, 1);
    check("R5 3C value", last_rd, 32'h3C3C3C3C);
    access("R3 half F00D", 4'h2, 2'b01, 32'hBEEFF00D, 1, 0);
    access("R3 check F00D", 4'h0, 2'b11, 32'h0, 0, 1);
    check("R3 R9 F00D value", last_rd, 32'hF00DF00D);
    // R4 size 11 write
    access("R4 wide write", 4'h7, 2'b11, 32'hCAFE0123, 1, 0);
    access("R4 R9 wide read", 4'h4, 2'b11, 32'h0, 0, 1);
    check("R4 value", last_rd, 32'hCAFE0123);
    // R6 other registers untouched
    access("R6 reg2 read", 4'h8, 2'b10, 32'h0, 0, 1);
    check("R6 reg2 zero", last_rd, 32'h0);
    access("R6 reg0 kept", 4'h0, 2'b10, 32'h0, 0, 1);
    check("R6 reg0 value", last_rd, 32'hF00DF00D);
    // R10 read and write in the same cycle returns the old value
    access("R10 rw same cycle", 4'hC, 2'b10, 32'h89ABCDEF, 1, 1);
    check("R10 old value", last_rd, 32'h0);
    access("R10 new value", 4'hC, 2'b10, 32'h0, 0, 1);
    check("R10 new value", last_rd, 32'h89ABCDEF);

    for (int n = 0; n < 400; n++) begin
      logic [3:0]  a;
      logic [1:0]  sz;
      logic [31:0] d;
      bit we, re;
      a = 4'($urandom); sz = 2'($urandom); d = $urandom;
      we = bit'($urandom_range(0, 1)); re = bit'($urandom_range(0, 1));
      access("random R5 R6 R7 R8 R9", a, sz, d, we, re);
    end
    for (int i = 0; i < 4; i++) access("final R6", 4'(i*4), 2'b10, 32'h0, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule